// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input rate by a programmable integer and emits a single-cycle pulse each time the count completes. Such a pulse would feed a phase comparator in a frequency synthesizer loop. The fast input is a clock-enable (`in_en`) that is sampled on the system clock. The division uses three parts. A dual-modulus prescaler divides by P or P+1. A swallow counter holds the prescaler in P+1 mode for its first A output pulses of each cycle. A main counter ends the cycle after B prescaler pulses. The resulting ratio is N = B·P + A.

Software-facing logic supplies the prescaler select and the A and B values as plain inputs. The divider copies them into shadow registers only at the boundary between output cycles. A setting with B smaller than A, or with B equal to zero, cannot be realised. Such a setting raises `cfg_err`, and the counters are held cleared until a usable setting appears.

Top module: `pswal_divider`

## Requirements
- R1: With a valid setting and continuous enables, successive `div_pulse` pulses are exactly B·P + A enabled input cycles apart.
- R2: The select code `p_sel` chooses P = 8 << p_sel: code 0 gives 8/9, 1 gives 16/17, 2 gives 32/33, 3 gives 64/65.
- R3: `div_pulse` is high for exactly one clock per output cycle.
- R4: With A = 0 the prescaler stays in P mode all cycle, so the period is B·P.
- R5: With A = B every prescaler pulse uses P+1, so the period is B·(P+1).
- R6: If B < A or B = 0, `cfg_err` is high from the next clock edge that loads the setting, and no pulse appears. While the error is present the inputs are re-sampled every clock, and a valid setting clears the flag and restarts division.
- R7: Changes on `p_sel`, `a_val` or `b_val` during an output cycle do not alter that cycle's length. They are adopted at the edge that produces the next `div_pulse`.
- R8: The counters advance only on clocks where `in_en` is high. With `in_en` low no pulse is produced, and with `in_en` high every other clock the period in clocks doubles.
- R9: While `rst_n` is low, `div_pulse` and `cfg_err` are 0. The first clock after reset samples the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | Fast-input tick, one count per high clock |
| p_sel | input | 2 | Prescaler pair select |
| a_val | input | 6 | Swallow count A |
| b_val | input | 11 | Main count B |
| div_pulse | output | 1 | One-clock pulse per N enabled cycles |
| cfg_err | output | 1 | Setting unusable, divider held |

## Verification
The hardest situation to reach is a setting change in the middle of an output cycle. The change must not disturb the running count, and it must take effect on exactly the next boundary. The bench therefore changes the inputs on the falling edge just after a pulse. It then measures two consecutive intervals and expects the old ratio first and the new ratio second. The same timing is used to move from a running state into an unusable setting: the bench checks that the error flag rises together with the final pulse and that nothing is emitted afterwards.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

  localparam int unsigned DEF_A_W      = 6;
  localparam int unsigned DEF_B_W      = 11;
  localparam int unsigned DEF_SEL_W    = 2;
  localparam int unsigned DEF_LOG_PMIN = 3;

  // smaller modulus of the selected prescaler pair
  function automatic int unsigned pre_modulus(input int unsigned sel,
                                              input int unsigned log_min);
    return 32'd1 << (log_min + sel);
  endfunction

  // a setting is usable only if enough main pulses exist to swallow A
  function automatic logic cfg_usable(input int unsigned a,
                                      input int unsigned b);
    return (b != 0) && (b >= a);
  endfunction

  function automatic int unsigned total_ratio(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned sel,
                                              input int unsigned log_min);
    return b * pre_modulus(sel, log_min) + a;
  endfunction

endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int unsigned PC_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [PC_W-1:0] last_idx,
  output logic            wrap,
  output logic [PC_W-1:0] count
);
  logic [PC_W-1:0] cnt_q;

  assign wrap  = tick && !clr && (cnt_q == last_idx);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswal_swallow.sv
module pswal_swallow #(
  parameter int unsigned A_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  input  logic [A_W-1:0] limit,
  output logic           extra_mode,
  output logic [A_W-1:0] count
);
  logic [A_W-1:0] cnt_q;

  assign extra_mode = (cnt_q < limit);
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (step && extra_mode)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswal_main.sv
module pswal_main #(
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  input  logic [B_W-1:0] limit,
  output logic           term,
  output logic [B_W-1:0] count
);
  logic [B_W-1:0] cnt_q;

  assign term  = step && !clr && (cnt_q == (limit - 1'b1));
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (term)   cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
#(
  parameter int unsigned A_W      = DEF_A_W,
  parameter int unsigned B_W      = DEF_B_W,
  parameter int unsigned SEL_W    = DEF_SEL_W,
  parameter int unsigned LOG_PMIN = DEF_LOG_PMIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [SEL_W-1:0] p_sel,
  input  logic [A_W-1:0]   a_val,
  input  logic [B_W-1:0]   b_val,
  output logic             div_pulse,
  output logic             cfg_err
);
  // wide enough for the largest modulus P+1
  localparam int unsigned PC_W = LOG_PMIN + (1 << SEL_W);

  logic [SEL_W-1:0] p_cur;
  logic [A_W-1:0]   a_cur;
  logic [B_W-1:0]   b_cur;
  logic             run;
  logic             err_q;
  logic             pulse_q;

  // named internal events
  logic             tick;
  logic             pre_wrap;
  logic             extra_mode;
  logic             cycle_end;
  logic             load;
  logic             in_ok;
  logic [PC_W-1:0]  p_val;
  logic [PC_W-1:0]  last_idx;
  logic [PC_W-1:0]  pre_cnt;
  logic [A_W-1:0]   swallow_cnt;
  logic [B_W-1:0]   main_cnt;

  assign tick     = in_en && run;
  assign in_ok    = cfg_usable(32'(a_val), 32'(b_val));
  assign load     = !run || cycle_end;
  assign p_val    = PC_W'(pre_modulus(32'(p_cur), LOG_PMIN));
  assign last_idx = extra_mode ? p_val : (p_val - 1'b1);

  pswal_prescaler #(.PC_W(PC_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!run),
    .tick     (tick),
    .last_idx (last_idx),
    .wrap     (pre_wrap),
    .count    (pre_cnt)
  );

  pswal_swallow #(.A_W(A_W)) u_swal (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!run || cycle_end),
    .step       (pre_wrap),
    .limit      (a_cur),
    .extra_mode (extra_mode),
    .count      (swallow_cnt)
  );

  pswal_main #(.B_W(B_W)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .step  (pre_wrap),
    .limit (b_cur),
    .term  (cycle_end),
    .count (main_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cur   <= '0;
      a_cur   <= '0;
      b_cur   <= '0;
      run     <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= cycle_end;
      if (load) begin
        p_cur <= p_sel;
        a_cur <= a_val;
        b_cur <= b_val;
        run   <= in_ok;
        err_q <= !in_ok;
      end
    end
  end

  assign div_pulse = pulse_q;
  assign cfg_err   = err_q;

endmodule

// File: rtl/pswal_checker.sv
module pswal_checker #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 11,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PC_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_en,
  input logic             div_pulse,
  input logic             cfg_err,
  input logic             run,
  input logic [SEL_W-1:0] p_cur,
  input logic [A_W-1:0]   a_cur,
  input logic [B_W-1:0]   b_cur,
  input logic [PC_W-1:0]  p_val,
  input logic [PC_W-1:0]  pre_cnt,
  input logic [A_W-1:0]   swallow_cnt,
  input logic [B_W-1:0]   main_cnt
);
  p_swallow_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (swallow_cnt <= a_cur));

  p_main_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (main_cnt < b_cur));

  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt <= p_val));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_err_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !run);

  p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> !div_pulse);

  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !div_pulse) |->
      ($stable(a_cur) && $stable(b_cur) && $stable(p_cur)));

  p_pulse_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(in_en));
endmodule

bind pswal_divider pswal_checker #(
  .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .PC_W(PC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_en       (in_en),
  .div_pulse   (div_pulse),
  .cfg_err     (cfg_err),
  .run         (run),
  .p_cur       (p_cur),
  .a_cur       (a_cur),
  .b_cur       (b_cur),
  .p_val       (p_val),
  .pre_cnt     (pre_cnt),
  .swallow_cnt (swallow_cnt),
  .main_cnt    (main_cnt)
);

// File: tb/pswal_divider_test.sv
module pswal_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_en = 1'b1;
  logic [1:0]  p_sel = '0;
  logic [5:0]  a_val = '0;
  logic [10:0] b_val = 11'd1;
  logic        div_pulse;
  logic        cfg_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic gap_mode = 1'b0;

  always #2.5 clk = ~clk;

  pswal_divider uut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .p_sel(p_sel),
    .a_val(a_val), .b_val(b_val), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  localparam int NV = 8;
  localparam int V_SEL [NV] = '{0, 0, 0, 1, 2, 3, 0, 3};
  localparam int V_A   [NV] = '{0, 1, 3, 5, 0, 2, 63, 10};
  localparam int V_B   [NV] = '{1, 1, 5, 7, 3, 2, 63, 40};
  localparam int V_N   [NV] = '{8, 9, 43, 117, 96, 130, 567, 2570};

  always @(negedge clk) if (gap_mode) in_en = ~in_en;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int clocks, input int limit);
    clocks = 0;
    do begin
      @(negedge clk);
      clocks++;
    end while (!div_pulse && clocks < limit);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_pulse) cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setcfg(input int s, input int a, input int b);
    p_sel = 2'(s);
    a_val = 6'(a);
    b_val = 11'(b);
  endtask

  initial begin
    int t1, t2, t0, n;
    // R9: reset state
    @(negedge clk);
    check("R9 pulse in reset", int'(div_pulse), 0);
    check("R9 err in reset", int'(cfg_err), 0);

    // table walk: R1, R2, R4, R5
    for (int v = 0; v < NV; v++) begin
      setcfg(V_SEL[v], V_A[v], V_B[v]);
      do_reset();
      wait_pulse(t0, 6000);
      wait_pulse(t1, 6000);
      wait_pulse(t2, 6000);
      if (V_A[v] == 0) begin
        check("R4 A=0 period", t1, V_N[v]);
        check("R4 A=0 period again", t2, V_N[v]);
      end else if (V_A[v] == V_B[v]) begin
        check("R5 A=B period", t1, V_N[v]);
        check("R5 A=B period again", t2, V_N[v]);
      end else begin
        check("R1/R2 period", t1, V_N[v]);
        check("R1/R2 period again", t2, V_N[v]);
      end
    end

    // R3: pulse width one clock
    setcfg(0, 1, 1);
    do_reset();
    wait_pulse(t0, 100);
    @(negedge clk);
    check("R3 pulse width", int'(div_pulse), 0);

    // R6: B < A
    setcfg(0, 5, 3);
    do_reset();
    repeat (3) @(negedge clk);
    check("R6 err B<A", int'(cfg_err), 1);
    count_pulses(300, n);
    check("R6 no pulse in error", n, 0);
    b_val = 11'd5;
    repeat (2) @(negedge clk);
    check("R6 err cleared", int'(cfg_err), 0);
    wait_pulse(t0, 200);
    wait_pulse(t1, 200);
    check("R6 recovered period", t1, 45);

    // R6: B = 0
    setcfg(1, 0, 0);
    do_reset();
    repeat (3) @(negedge clk);
    check("R6 err B=0", int'(cfg_err), 1);

    // R7: change mid-cycle
    setcfg(0, 1, 2);
    do_reset();
    wait_pulse(t0, 200);
    wait_pulse(t0, 200);
    setcfg(0, 2, 4);
    wait_pulse(t1, 200);
    wait_pulse(t2, 200);
    check("R7 old ratio kept", t1, 17);
    check("R7 new ratio adopted", t2, 34);

    // R7/R6: unusable setting during run
    setcfg(0, 1, 2);
    do_reset();
    wait_pulse(t0, 200);
    setcfg(0, 9, 3);
    wait_pulse(t1, 200);
    check("R7 last cycle intact", t1, 17);
    check("R6 err with last pulse", int'(cfg_err), 1);
    count_pulses(100, n);
    check("R6 silent after err", n, 0);

    // R8: enable held low, then gapped
    setcfg(0, 1, 1);
    in_en = 1'b0;
    do_reset();
    count_pulses(100, n);
    check("R8 no pulse without enable", n, 0);
    gap_mode = 1'b1;
    wait_pulse(t0, 200);
    wait_pulse(t1, 200);
    check("R8 gapped period", t1, 18);
    gap_mode = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule